// File: doc/BRIEF.md
# Synchronous Serial Shift Port

A byte-wide, memory-mapped serial port that shifts one byte per transfer as the clock master. The CPU writes the data register to launch a transfer. The port then drives a serial clock at one quarter of the system clock and sends the byte most-significant bit first on the serial output. At the same time it captures the serial input into the same register. There is only one data register, and it holds both the byte to send and the byte received.

Two sticky status flags report progress. One is a completion flag and the other is a collision flag, which catches a data-register access made while bits are on the wire. Both flags clear in two steps: a status read that sees the flag set, then an access to the data register. The port must be enabled for the data register to respond. A control bit selects the idle level of the serial clock.

Top module: `sio_port`

## Requirements
- R1: After reset the status register reads 0x00, the control register reads 0x00, the data register reads 0x00 and the serial clock is low.
- R2: The control register is at 0x0A, with the enable bit at bit 0 and the clock polarity bit at bit 1; its other bits read 0. The status register is at 0x0B, with the completion flag at bit 7 and the collision flag at bit 6; bits 5..0 read 0. The data register is at 0x0C. `rdata_o` always shows the register that `addr_i` selects. `rd_i` only marks a read for the status side effects.
- R3: A data-register write while the port is enabled and idle starts an 8-bit transfer. The serial clock then makes 16 edges, one every 2 system clocks, starting 2 clocks after the write. The serial output shows bit 7 of the written byte first and moves to the next bit on every second edge. The serial input is sampled on the odd-numbered edges. After the 16th edge the data register holds the received byte.
- R4: While idle, the serial clock sits at the polarity bit. The first edge of a transfer leaves that level and the last edge returns to it.
- R5: The completion flag sets on the 16th serial clock edge, 32 system clocks after the starting write, and is not set on the cycle before.
- R6: A flag clears only when a status read sees it set and the next enabled data-register access follows. A data access with no such status read leaves the flag set.
- R7: If the completion flag is cleared before a following byte ends, it sets again on that byte's last edge.
- R8: The collision flag sets when the data register is read or written after the first serial clock edge of a transfer and before the completion flag sets. An access before the first edge does not set it. Writes to the status register have no effect.
- R9: The collision flag clears by the same two-step sequence. If the final data access of that sequence falls inside an active transfer, the flag stays set.
- R10: With the enable bit at 0, data reads return 0, data writes change nothing and start nothing, and data accesses do not complete a pending two-step clear. Clearing the enable bit stops a transfer at once and returns the serial clock to its idle level.
- R11: A data-register write during a transfer is discarded. The byte still being shifted out and the byte received are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register address |
| rd_i | input | 1 | Read strobe (drives status side effects) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The bench checks the serial clock and the serial output bit by bit on every system clock, in both polarities. A divider or edge counter that is off by one, or a shift on the wrong edge, breaks the pattern or moves the completion flag by a cycle. It then runs the two-step clear: with no arming status read, in the normal order, in a sequence that lets the flag set again, and with the final access placed inside an active transfer. A design that clears too easily, or that lets clear win over set, loses a flag it should hold. It makes data accesses just before the first edge and just after it to pin down the edge of the collision window. It also writes while the port is disabled and disables it mid-transfer, which catches a port that leaks writes, consumes the arming, or keeps clocking.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h0A;
  localparam logic [7:0] ADDR_STAT = 8'h0B;
  localparam logic [7:0] ADDR_DATA = 8'h0C;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_POL_BIT  = 1;
  localparam int STAT_DONE_BIT = 7;
  localparam int STAT_COL_BIT  = 6;
endpackage

// File: rtl/sio_sck_gen.sv
module sio_sck_gen #(
  parameter int HALF_DIV = 2,
  parameter int EDGES    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  input  logic pol_i,
  output logic sck_o,
  output logic busy_o,
  output logic lead_o,
  output logic trail_o,
  output logic last_o,
  output logic active_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int EW = $clog2(EDGES + 1);

  logic [DW-1:0] div_q;
  logic [EW-1:0] edge_q;
  logic          busy_q, sck_q, tick;

  assign tick     = busy_q && (div_q == DW'(HALF_DIV - 1));
  assign lead_o   = tick && !edge_q[0];
  assign trail_o  = tick && edge_q[0];
  assign last_o   = tick && (edge_q == EW'(EDGES - 1));
  assign active_o = busy_q && (edge_q != '0);
  assign sck_o    = sck_q;
  assign busy_o   = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      div_q  <= '0;
      edge_q <= '0;
    end else if (abort_i || start_i) begin
      busy_q <= start_i && !abort_i;
      sck_q  <= pol_i;
      div_q  <= '0;
      edge_q <= '0;
    end else if (busy_q) begin
      if (tick) begin
        div_q  <= '0;
        sck_q  <= ~sck_q;
        edge_q <= last_o ? '0 : edge_q + 1'b1;
        if (last_o) busy_q <= 1'b0;
      end else begin
        div_q <= div_q + 1'b1;
      end
    end else begin
      sck_q <= pol_i;
    end
  end

  // idle clock follows polarity
  assert_idle_level_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> (sck_q == $past(pol_i)));
  assert_edge_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (edge_q < EW'(EDGES)));
  assert_clock_moves_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !abort_i && !start_i && tick) |=> (sck_q != $past(sck_q)));
endmodule

// File: rtl/sio_shift_reg.sv
module sio_shift_reg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lead_i,
  input  logic         trail_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic [W-1:0] data_o
);
  logic [W-1:0] sreg_q;
  logic         samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      samp_q <= 1'b0;
    end else begin
      if (load_i)       sreg_q <= load_data_i;
      else if (trail_i) sreg_q <= {sreg_q[W-2:0], samp_q};
      if (lead_i) samp_q <= sdi_i;
    end
  end

  assign sdo_o  = sreg_q[W-1];
  assign data_o = sreg_q;

  // loads never collide with shifting (busy writes dropped)
  assert_load_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !(lead_i || trail_i));
  assert_hold_between_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !trail_i) |=> $stable(sreg_q));
endmodule

// File: rtl/sio_status.sv
module sio_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stat_rd_i,
  input  logic data_acc_i,
  input  logic last_i,
  input  logic active_i,
  output logic done_o,
  output logic col_o
);
  logic done_q, col_q, arm_done_q, arm_col_q;
  logic clr_done, clr_col, col_set;

  assign clr_done = data_acc_i && arm_done_q;
  assign clr_col  = data_acc_i && arm_col_q;
  assign col_set  = data_acc_i && active_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q     <= 1'b0;
      col_q      <= 1'b0;
      arm_done_q <= 1'b0;
      arm_col_q  <= 1'b0;
    end else begin
      done_q <= last_i  || (done_q && !clr_done);
      col_q  <= col_set || (col_q && !clr_col);
      if (stat_rd_i) begin
        arm_done_q <= done_q;
        arm_col_q  <= col_q;
      end else if (data_acc_i) begin
        arm_done_q <= 1'b0;
        arm_col_q  <= 1'b0;
      end
    end
  end

  assign done_o = done_q;
  assign col_o  = col_q;

  assert_done_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> done_q);
  assert_done_unarmed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !arm_done_q) |=> done_q);
  assert_col_unarmed_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (col_q && !arm_col_q) |=> col_q);
  assert_col_sets_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc_i && active_i) |=> col_q);
endmodule

// File: rtl/sio_port.sv
module sio_port
  import sio_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sck_o,
  output logic              sdo_o,
  input  logic              sdi_i
);
  localparam int EDGES = 2 * DATA_W;

  logic en_q, pol_q;
  logic sel_ctrl, sel_stat, sel_data;
  logic data_acc, start, stat_rd;
  logic busy_w, lead_w, trail_w, last_w, active_w, done_w, col_w;
  logic [DATA_W-1:0] sreg_w;

  assign sel_ctrl = (addr_i == ADDR_CTRL);
  assign sel_stat = (addr_i == ADDR_STAT);
  assign sel_data = (addr_i == ADDR_DATA);
  assign data_acc = (rd_i || wr_i) && sel_data && en_q;
  assign start    = wr_i && sel_data && en_q && !busy_w;
  assign stat_rd  = rd_i && sel_stat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      pol_q <= 1'b0;
    end else if (wr_i && sel_ctrl) begin
      en_q  <= wdata_i[CTRL_EN_BIT];
      pol_q <= wdata_i[CTRL_POL_BIT];
    end
  end

  sio_sck_gen #(.HALF_DIV(HALF_DIV), .EDGES(EDGES)) u_sck (
    .clk_i, .rst_ni,
    .start_i (start),
    .abort_i (!en_q),
    .pol_i   (pol_q),
    .sck_o   (sck_o),
    .busy_o  (busy_w),
    .lead_o  (lead_w),
    .trail_o (trail_w),
    .last_o  (last_w),
    .active_o(active_w)
  );

  sio_shift_reg #(.W(DATA_W)) u_shift (
    .clk_i, .rst_ni,
    .load_i     (start),
    .load_data_i(wdata_i),
    .lead_i     (lead_w),
    .trail_i    (trail_w),
    .sdi_i      (sdi_i),
    .sdo_o      (sdo_o),
    .data_o     (sreg_w)
  );

  sio_status u_stat (
    .clk_i, .rst_ni,
    .stat_rd_i (stat_rd),
    .data_acc_i(data_acc),
    .last_i    (last_w),
    .active_i  (active_w),
    .done_o    (done_w),
    .col_o     (col_w)
  );

  always_comb begin
    rdata_o = '0;
    if (sel_ctrl) begin
      rdata_o[CTRL_EN_BIT]  = en_q;
      rdata_o[CTRL_POL_BIT] = pol_q;
    end else if (sel_stat) begin
      rdata_o[STAT_DONE_BIT] = done_w;
      rdata_o[STAT_COL_BIT]  = col_w;
    end else if (sel_data && en_q) begin
      rdata_o = sreg_w;
    end
  end

  assert_stat_pad_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_stat |-> (rdata_o[5:0] == '0));
  assert_dis_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_data && !en_q) |-> (rdata_o == '0));
  assert_dis_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |=> !busy_w);
endmodule

// File: tb/tb_sio_port.sv
`timescale 1ns/1ps
module tb_sio_port;
  localparam logic [7:0] A_CTRL = 8'h0A, A_STAT = 8'h0B, A_DATA = 8'h0C;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [7:0] addr_i = 8'h00, wdata_i = 8'h00;
  logic rd_i = 1'b0, wr_i = 1'b0, sdi_i = 1'b0;
  logic [7:0] rdata_o;
  logic sck_o, sdo_o;
  int total = 0, bad = 0;

  always #10 clk_i = ~clk_i;

  sio_port dut (.clk_i, .rst_ni, .addr_i, .rd_i, .wr_i, .wdata_i,
                .rdata_o, .sck_o, .sdo_o, .sdi_i);

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    addr_i = a; rd_i = 1'b1; #1 d = rdata_o;
    @(negedge clk_i); rd_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic peek(input string req, input string what, input logic [7:0] a, input logic [7:0] exp);
    addr_i = a; #1 chk(req, what, rdata_o, exp);
  endtask

  task automatic do_xfer(input logic pol, input logic [7:0] tx, input logic [7:0] rx,
                         input bit mid, input logic [7:0] pre, input string tag);
    int e_sck = 0, e_sdo = 0;
    logic [7:0] d, colb;
    colb = mid ? 8'h40 : 8'h00;
    bus_wr(A_DATA, tx);
    addr_i = A_STAT; sdi_i = rx[7];
    if (sdo_o !== tx[7]) e_sdo++;
    for (int k = 1; k <= 32; k++) begin
      @(negedge clk_i);
      if (k == 10) begin wr_i = 1'b0; addr_i = A_STAT; end
      #1;
      if (sck_o !== (pol ^ bit'((k / 2) % 2))) e_sck++;
      if (k < 32) begin
        if (sdo_o !== tx[7 - k / 4]) e_sdo++;
        sdi_i = rx[7 - k / 4];
      end
      if (k == 1)  chk(tag, "status at first clock", rdata_o, pre);
      if (k == 31) chk("R5", "status before last edge", rdata_o, pre | colb);
      if (k == 32) chk(tag, "status at last edge", rdata_o, pre | colb | 8'h80);
      if (k == 9 && mid) begin addr_i = A_DATA; wdata_i = ~tx; wr_i = 1'b1; end
    end
    chk("R4", "sck pattern mismatches", e_sck, 0);
    chk(mid ? "R11" : "R3", "sdo pattern mismatches", e_sdo, 0);
    bus_rd(A_DATA, d);
    chk(mid ? "R11" : "R3", "received byte", d, rx);
    peek("R6", "flag kept without arming read", A_STAT, pre | colb | 8'h80);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    bus_rd(A_STAT, d); chk("R1", "status after reset", d, 8'h00);
    bus_rd(A_CTRL, d); chk("R1", "control after reset", d, 8'h00);
    chk("R1", "sck after reset", sck_o, 1'b0);
    bus_rd(A_DATA, d); chk("R1", "data after reset", d, 8'h00);
  endtask

  task automatic t_ctrl;
    logic [7:0] d;
    bus_wr(A_CTRL, 8'hFF);
    bus_rd(A_CTRL, d); chk("R2", "control unused bits", d, 8'h03);
    #1 chk("R4", "idle sck with polarity 1", sck_o, 1'b1);
    bus_wr(A_CTRL, 8'h01); idle(1);
    #1 chk("R4", "idle sck with polarity 0", sck_o, 1'b0);
  endtask

  task automatic t_clear;
    logic [7:0] d;
    bus_rd(A_STAT, d); chk("R2", "completion at bit 7", d, 8'h80);
    bus_rd(A_DATA, d);
    peek("R6", "two-step clear", A_STAT, 8'h00);
  endtask

  task automatic t_col_ro;
    bus_wr(A_STAT, 8'h00);
    peek("R8", "status write ignored", A_STAT, 8'hC0);
  endtask

  task automatic t_col_reset;
    logic [7:0] d;
    bus_rd(A_STAT, d); chk("R9", "arming read", d, 8'hC0);
    bus_wr(A_DATA, 8'h33); idle(4);
    bus_rd(A_DATA, d);
    peek("R8", "access in window", A_STAT, 8'h40);
    bus_rd(A_STAT, d);
    bus_rd(A_DATA, d);
    peek("R9", "late final step keeps collision", A_STAT, 8'h40);
    idle(40);
    peek("R9", "after byte", A_STAT, 8'hC0);
    bus_rd(A_STAT, d); bus_rd(A_DATA, d);
    peek("R9", "collision cleared when idle", A_STAT, 8'h00);
  endtask

  task automatic t_early;
    logic [7:0] d;
    sdi_i = 1'b1;
    bus_wr(A_DATA, 8'h12);
    bus_rd(A_DATA, d);
    idle(40);
    peek("R8", "access before first edge", A_STAT, 8'h80);
  endtask

  task automatic t_disable;
    logic [7:0] d;
    int e = 0;
    bus_rd(A_STAT, d);
    bus_wr(A_CTRL, 8'h00);
    bus_rd(A_DATA, d); chk("R10", "disabled data read", d, 8'h00);
    bus_wr(A_DATA, 8'h55);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); #1 if (sck_o !== 1'b0) e++;
    end
    chk("R10", "sck quiet while disabled", e, 0);
    bus_wr(A_CTRL, 8'h01);
    peek("R10", "disabled access keeps flag", A_STAT, 8'h80);
    bus_rd(A_DATA, d); chk("R10", "disabled write dropped", d, 8'hFF);
    peek("R10", "arming survived disable", A_STAT, 8'h00);
  endtask

  task automatic t_abort;
    int e = 0;
    bus_wr(A_CTRL, 8'h03); idle(2);
    bus_wr(A_DATA, 8'h0F); idle(6);
    bus_wr(A_CTRL, 8'h02); idle(3);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk_i); #1 if (sck_o !== 1'b1) e++;
    end
    chk("R10", "sck idle after abort", e, 0);
    peek("R10", "no completion after abort", A_STAT, 8'h00);
    bus_wr(A_CTRL, 8'h03); idle(2);
  endtask

  initial begin
    logic [7:0] d;
    idle(3); rst_ni = 1'b1; idle(2);
    t_reset();
    t_ctrl();
    do_xfer(1'b0, 8'hA5, 8'h3C, 1'b0, 8'h00, "R5");
    t_clear();
    bus_wr(A_CTRL, 8'h03); idle(2);
    do_xfer(1'b1, 8'h96, 8'hE1, 1'b0, 8'h00, "R4");
    bus_rd(A_STAT, d);
    do_xfer(1'b1, 8'h3C, 8'h5A, 1'b0, 8'h00, "R7");
    bus_rd(A_STAT, d);
    do_xfer(1'b1, 8'h5A, 8'hC3, 1'b1, 8'h00, "R8");
    t_col_ro();
    t_col_reset();
    t_early();
    t_disable();
    t_abort();
    do_xfer(1'b1, 8'h81, 8'h7E, 1'b0, 8'h00, "R10");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule